// File: doc/BRIEF.md
# Competitive Write-Update Line Snooper

This block holds the coherence state for every line of one cache in a write-update snooping system. The processor side issues reads and writes. The bus side shows each transaction that any cache puts on the shared bus, including this cache's own transactions when they come back. Lines are single-word and direct-mapped. Each line has a tag, a data word and one of three valid states: exclusive-clean, shared or dirty. A write to a shared line asks for a write broadcast. Memory takes that data in the same bus transaction, so after the broadcast the line stays clean.

Each line also has a small saturating down-counter. Its preset equals the cost, in bus cycles, of refetching a block. Foreign write broadcasts that hit the line count it down. When it reaches zero the copy is dropped, but the tag is kept and the line is marked stale. A later reread broadcast from another cache refills the stale copy. While a copy is held, this cache drives a registered "shared" response, which the system wire-ORs. A cache whose own broadcast comes back with no shared response sets its line to exclusive, and it stops broadcasting writes to that line.

Each cycle the block applies its updates to a line in a fixed order. First it settles its own pending transaction. Then it applies the snooped bus transaction. The processor access comes last.

Top module: `coh_update_snooper`

## Requirements
- R1: After reset every line is invalid and all registered outputs are low, so a first processor read reports a miss.
- R2: A processor miss raises `bc_req` one cycle later, with the same address and `bc_wr` equal to the access type. When that transaction returns as a bus operation from this cache's own ID (bus_op 1 = read broadcast, 2 = write broadcast), it installs the bus data. The line becomes exclusive-clean if `shared_in` is low in the next cycle, and shared otherwise.
- R3: A processor write to an exclusive-clean or dirty line raises no bus request and leaves the line dirty. A foreign read broadcast to a dirty line returns the line's data on `sup_data` with `sup_valid` one cycle later, asserts `shared_out`, and leaves the line shared.
- R4: A processor write to a shared line updates the local copy and requests a write broadcast carrying the address and the new data. If no other cache signals sharing after that broadcast, the line becomes exclusive-clean, and later writes to it cause no bus request.
- R5: A foreign write broadcast that hits a held line and leaves its counter above zero replaces the line's data and raises `shared_out` in the next cycle.
- R6: RELOAD consecutive foreign write broadcasts from one source invalidate the line. `shared_out` stays low after the last of them, and a later processor access misses.
- R7: A foreign write broadcast from a source other than the last one seen on that line presets the counter to RELOAD before decrementing it.
- R8: A processor hit presets the line's counter to RELOAD. The counter never exceeds RELOAD.
- R9: A foreign read broadcast to a line dropped by its counter (same tag) refills it with the bus data. The line becomes shared, its counter is preset, and `shared_out` is raised.
- R10: When a snooped transaction and a processor access hit the same line in the same cycle, the snoop takes effect first. The processor sees the updated data, or a miss if the snoop dropped the line.
- R11: Transactions on the bus from this cache's own ID never raise `shared_out` and never count down a counter.
- R12: Bus transactions to an address whose tag is not held have no effect on the line, and they raise neither `shared_out` nor `sup_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access this cycle |
| cpu_wr | input | 1 | Access is a write |
| cpu_addr | input | AW | Word address (low IW bits index the line) |
| cpu_wdata | input | DW | Write data |
| cpu_done | output | 1 | Registered: access was handled |
| cpu_hit | output | 1 | Registered: access hit a valid line |
| cpu_rdata | output | DW | Registered: line data on a hit |
| bc_req | output | 1 | Registered: bus transaction request |
| bc_wr | output | 1 | Request is a write broadcast (else read) |
| bc_addr | output | AW | Request address |
| bc_data | output | DW | Write data for a write broadcast |
| bus_valid | input | 1 | A bus transaction is visible |
| bus_op | input | 2 | 1 = read broadcast, 2 = write broadcast |
| bus_addr | input | AW | Transaction address |
| bus_data | input | DW | Transaction data |
| bus_src | input | IDW | ID of the issuing cache |
| shared_in | input | 1 | Wired-OR shared line, one cycle after a transaction |
| shared_out | output | 1 | Registered: this cache still holds the snooped line |
| sup_valid | output | 1 | Registered: dirty data supplied for a read broadcast |
| sup_data | output | DW | Supplied data |

## Verification
The processor side and the bus side can both touch the same line in one cycle. The bench provokes this by driving a foreign write broadcast and a processor read to the same address at one clock edge. It does this once while the counter still has room, and once when the broadcast takes the counter to zero. In the first case the processor read must return the broadcast data as a hit. In the second it must miss and issue a read request, and `shared_out` must stay low.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_I  = 2'd0,
    ST_VE = 2'd1,
    ST_SH = 2'd2,
    ST_DT = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2,
    OP_RSV  = 2'd3
  } bus_op_e;

endpackage

// File: rtl/coh_bus_step.sv
// Applies pending-transaction resolution and one snooped bus operation to a line.
module coh_bus_step
  import coh_pkg::*;
#(
  parameter int TW     = 5,
  parameter int DW     = 16,
  parameter int CW     = 2,
  parameter int IDW    = 2,
  parameter int RELOAD = 3,
  parameter int MY_ID  = 0
) (
  input  line_st_e          st_i,
  input  logic              stale_i,
  input  logic [TW-1:0]     tag_i,
  input  logic [DW-1:0]     data_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic [IDW-1:0]    last_i,
  input  logic              resolve_i,
  input  logic              shared_in,
  input  logic              sel_i,
  input  bus_op_e           op_i,
  input  logic [TW-1:0]     btag_i,
  input  logic [DW-1:0]     bdata_i,
  input  logic [IDW-1:0]    bsrc_i,
  output line_st_e          st_o,
  output logic              stale_o,
  output logic [TW-1:0]     tag_o,
  output logic [DW-1:0]     data_o,
  output logic [CW-1:0]     cnt_o,
  output logic [IDW-1:0]    last_o,
  output logic              shared_o,
  output logic              supply_o,
  output logic [DW-1:0]     sup_data_o
);

  localparam logic [CW-1:0]  RLD = CW'(RELOAD);
  localparam logic [IDW-1:0] ME  = IDW'(MY_ID);

  line_st_e      st0;
  logic          tmatch;
  logic          own;
  logic [CW-1:0] base;
  logic [CW-1:0] nxt;

  always_comb begin
    st0 = st_i;
    if (resolve_i && st_i == ST_SH && !shared_in) st0 = ST_VE;

    st_o       = st0;
    stale_o    = stale_i;
    tag_o      = tag_i;
    data_o     = data_i;
    cnt_o      = cnt_i;
    last_o     = last_i;
    shared_o   = 1'b0;
    supply_o   = 1'b0;
    sup_data_o = '0;
    tmatch     = (tag_i == btag_i);
    own        = (bsrc_i == ME);
    base       = (bsrc_i != last_i) ? RLD : cnt_i;
    nxt        = (base == '0) ? '0 : base - 1'b1;

    if (sel_i && own) begin
      if (op_i == OP_WR && tmatch && st0 != ST_I) begin
        data_o = bdata_i;
      end else begin
        st_o    = ST_SH;
        stale_o = 1'b0;
        tag_o   = btag_i;
        data_o  = bdata_i;
        cnt_o   = RLD;
        last_o  = ME;
      end
    end else if (sel_i && tmatch && op_i == OP_WR && st0 != ST_I) begin
      cnt_o  = nxt;
      last_o = bsrc_i;
      if (nxt == '0) begin
        st_o    = ST_I;
        stale_o = 1'b1;
      end else begin
        st_o     = ST_SH;
        data_o   = bdata_i;
        shared_o = 1'b1;
      end
    end else if (sel_i && tmatch && op_i == OP_RD) begin
      if (st0 != ST_I) begin
        st_o     = ST_SH;
        shared_o = 1'b1;
        if (st0 == ST_DT) begin
          supply_o   = 1'b1;
          sup_data_o = data_i;
        end
      end else if (stale_i) begin
        st_o     = ST_SH;
        stale_o  = 1'b0;
        data_o   = bdata_i;
        cnt_o    = RLD;
        last_o   = ME;
        shared_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/coh_cpu_step.sv
// Applies one processor access to a line (after the snoop has been applied).
module coh_cpu_step
  import coh_pkg::*;
#(
  parameter int TW     = 5,
  parameter int DW     = 16,
  parameter int CW     = 2,
  parameter int IDW    = 2,
  parameter int RELOAD = 3,
  parameter int MY_ID  = 0
) (
  input  line_st_e       st_i,
  input  logic [TW-1:0]  tag_i,
  input  logic [DW-1:0]  data_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic [IDW-1:0] last_i,
  input  logic           sel_i,
  input  logic           wr_i,
  input  logic [TW-1:0]  ctag_i,
  input  logic [DW-1:0]  wdata_i,
  output line_st_e       st_o,
  output logic [DW-1:0]  data_o,
  output logic [CW-1:0]  cnt_o,
  output logic [IDW-1:0] last_o,
  output logic           hit_o,
  output logic [DW-1:0]  rdata_o,
  output logic           bc_o,
  output logic           bcwr_o
);

  localparam logic [CW-1:0]  RLD = CW'(RELOAD);
  localparam logic [IDW-1:0] ME  = IDW'(MY_ID);

  always_comb begin
    st_o    = st_i;
    data_o  = data_i;
    cnt_o   = cnt_i;
    last_o  = last_i;
    hit_o   = sel_i && st_i != ST_I && tag_i == ctag_i;
    rdata_o = '0;
    bc_o    = 1'b0;
    bcwr_o  = 1'b0;
    if (hit_o) begin
      rdata_o = data_i;
      cnt_o   = RLD;
      last_o  = ME;
      if (wr_i) begin
        data_o = wdata_i;
        if (st_i == ST_SH) begin
          bc_o   = 1'b1;
          bcwr_o = 1'b1;
        end else begin
          st_o = ST_DT;
        end
      end
    end else if (sel_i) begin
      bc_o   = 1'b1;
      bcwr_o = wr_i;
    end
  end

endmodule

// File: rtl/coh_update_snooper.sv
module coh_update_snooper
  import coh_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int NLINES = 8,
  parameter int IDW    = 2,
  parameter int MY_ID  = 0,
  parameter int RELOAD = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cpu_req,
  input  logic           cpu_wr,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic           cpu_done,
  output logic           cpu_hit,
  output logic [DW-1:0]  cpu_rdata,
  output logic           bc_req,
  output logic           bc_wr,
  output logic [AW-1:0]  bc_addr,
  output logic [DW-1:0]  bc_data,
  input  logic           bus_valid,
  input  logic [1:0]     bus_op,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_data,
  input  logic [IDW-1:0] bus_src,
  input  logic           shared_in,
  output logic           shared_out,
  output logic           sup_valid,
  output logic [DW-1:0]  sup_data
);

  localparam int IW = $clog2(NLINES);
  localparam int TW = AW - IW;
  localparam int CW = $clog2(RELOAD + 1);
  localparam logic [CW-1:0]  RLD = CW'(RELOAD);
  localparam logic [IDW-1:0] ME  = IDW'(MY_ID);

  line_st_e       st_q    [NLINES];
  logic           stale_q [NLINES];
  logic [TW-1:0]  tag_q   [NLINES];
  logic [DW-1:0]  data_q  [NLINES];
  logic [CW-1:0]  cnt_q   [NLINES];
  logic [IDW-1:0] last_q  [NLINES];
  logic           pend_q;
  logic [IW-1:0]  pend_idx_q;

  // after bus step
  line_st_e       st_b    [NLINES];
  logic           stale_b [NLINES];
  logic [TW-1:0]  tag_b   [NLINES];
  logic [DW-1:0]  data_b  [NLINES];
  logic [CW-1:0]  cnt_b   [NLINES];
  logic [IDW-1:0] last_b  [NLINES];
  logic           shr_b   [NLINES];
  logic           sup_b   [NLINES];
  logic [DW-1:0]  supd_b  [NLINES];
  // after processor step
  line_st_e       st_c    [NLINES];
  logic [DW-1:0]  data_c  [NLINES];
  logic [CW-1:0]  cnt_c   [NLINES];
  logic [IDW-1:0] last_c  [NLINES];
  logic           hit_c   [NLINES];
  logic [DW-1:0]  rdata_c [NLINES];
  logic           bc_c    [NLINES];
  logic           bcwr_c  [NLINES];

  bus_op_e        op_e;
  logic           bus_go;
  logic [IW-1:0]  bus_idx;
  logic [TW-1:0]  bus_tag;
  logic [IW-1:0]  cpu_idx;
  logic [TW-1:0]  cpu_tag;

  assign op_e    = bus_op_e'(bus_op);
  assign bus_go  = bus_valid && (op_e == OP_RD || op_e == OP_WR);
  assign bus_idx = bus_addr[IW-1:0];
  assign bus_tag = bus_addr[AW-1:IW];
  assign cpu_idx = cpu_addr[IW-1:0];
  assign cpu_tag = cpu_addr[AW-1:IW];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic sel_b;
    logic sel_c;
    logic res_b;
    assign sel_b = bus_go && bus_idx == IW'(i);
    assign sel_c = cpu_req && cpu_idx == IW'(i);
    assign res_b = pend_q && pend_idx_q == IW'(i);

    coh_bus_step #(
      .TW(TW), .DW(DW), .CW(CW), .IDW(IDW), .RELOAD(RELOAD), .MY_ID(MY_ID)
    ) u_bus (
      .st_i(st_q[i]), .stale_i(stale_q[i]), .tag_i(tag_q[i]), .data_i(data_q[i]),
      .cnt_i(cnt_q[i]), .last_i(last_q[i]), .resolve_i(res_b), .shared_in(shared_in),
      .sel_i(sel_b), .op_i(op_e), .btag_i(bus_tag), .bdata_i(bus_data), .bsrc_i(bus_src),
      .st_o(st_b[i]), .stale_o(stale_b[i]), .tag_o(tag_b[i]), .data_o(data_b[i]),
      .cnt_o(cnt_b[i]), .last_o(last_b[i]), .shared_o(shr_b[i]), .supply_o(sup_b[i]),
      .sup_data_o(supd_b[i])
    );

    coh_cpu_step #(
      .TW(TW), .DW(DW), .CW(CW), .IDW(IDW), .RELOAD(RELOAD), .MY_ID(MY_ID)
    ) u_cpu (
      .st_i(st_b[i]), .tag_i(tag_b[i]), .data_i(data_b[i]), .cnt_i(cnt_b[i]),
      .last_i(last_b[i]), .sel_i(sel_c), .wr_i(cpu_wr), .ctag_i(cpu_tag),
      .wdata_i(cpu_wdata), .st_o(st_c[i]), .data_o(data_c[i]), .cnt_o(cnt_c[i]),
      .last_o(last_c[i]), .hit_o(hit_c[i]), .rdata_o(rdata_c[i]), .bc_o(bc_c[i]),
      .bcwr_o(bcwr_c[i])
    );

    AST_LIVE_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
      (st_q[i] != ST_I) |-> (cnt_q[i] != '0)); // R6
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_q[i] <= RLD); // R8
  end

  logic          shr_any, sup_any, hit_any, bc_any, bcwr_any;
  logic [DW-1:0] supd_any, rdata_any;

  always_comb begin
    shr_any   = 1'b0;
    sup_any   = 1'b0;
    hit_any   = 1'b0;
    bc_any    = 1'b0;
    bcwr_any  = 1'b0;
    supd_any  = '0;
    rdata_any = '0;
    for (int i = 0; i < NLINES; i++) begin
      shr_any   = shr_any   | shr_b[i];
      sup_any   = sup_any   | sup_b[i];
      supd_any  = supd_any  | supd_b[i];
      hit_any   = hit_any   | hit_c[i];
      rdata_any = rdata_any | rdata_c[i];
      bc_any    = bc_any    | bc_c[i];
      bcwr_any  = bcwr_any  | bcwr_c[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]    <= ST_I;
        stale_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        data_q[i]  <= '0;
        cnt_q[i]   <= RLD;
        last_q[i]  <= ME;
      end
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      cpu_done   <= 1'b0;
      cpu_hit    <= 1'b0;
      cpu_rdata  <= '0;
      bc_req     <= 1'b0;
      bc_wr      <= 1'b0;
      bc_addr    <= '0;
      bc_data    <= '0;
      shared_out <= 1'b0;
      sup_valid  <= 1'b0;
      sup_data   <= '0;
    end else begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]    <= st_c[i];
        stale_q[i] <= stale_b[i];
        tag_q[i]   <= tag_b[i];
        data_q[i]  <= data_c[i];
        cnt_q[i]   <= cnt_c[i];
        last_q[i]  <= last_c[i];
      end
      pend_q     <= bus_go && bus_src == ME;
      pend_idx_q <= bus_idx;
      cpu_done   <= cpu_req;
      cpu_hit    <= hit_any;
      cpu_rdata  <= rdata_any;
      bc_req     <= bc_any;
      bc_wr      <= bcwr_any;
      bc_addr    <= cpu_addr;
      bc_data    <= bcwr_any ? cpu_wdata : '0;
      shared_out <= shr_any;
      sup_valid  <= sup_any;
      sup_data   <= supd_any;
    end
  end

  AST_OWN_SILENT: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_src == ME) |=> !shared_out); // R11
  AST_SUPPLY_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    sup_valid |-> $past(bus_valid && bus_op == 2'd1)); // R3
  AST_BC_FOLLOWS_CPU: assert property (@(posedge clk) disable iff (rst)
    bc_req |-> $past(cpu_req)); // R2
  AST_SHARED_FROM_BUS: assert property (@(posedge clk) disable iff (rst)
    shared_out |-> $past(bus_valid && bus_src != ME)); // R5

endmodule

// File: tb/coh_update_snooper_test.sv
module coh_update_snooper_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IDW = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [AW-1:0]  cpu_addr = '0;
  logic [DW-1:0]  cpu_wdata = '0;
  logic           cpu_done, cpu_hit, bc_req, bc_wr;
  logic [DW-1:0]  cpu_rdata, bc_data, sup_data;
  logic [AW-1:0]  bc_addr;
  logic           bus_valid = 1'b0;
  logic [1:0]     bus_op = 2'd0;
  logic [AW-1:0]  bus_addr = '0;
  logic [DW-1:0]  bus_data = '0;
  logic [IDW-1:0] bus_src = '0;
  logic           shared_in = 1'b0;
  logic           shared_out, sup_valid;

  int checks = 0;
  int errors = 0;

  // captured outputs
  logic          k_done, k_hit, k_bc, k_bcwr, k_shr, k_sup;
  logic [DW-1:0] k_rdata, k_bcdata, k_supd;
  logic [AW-1:0] k_bcaddr;

  localparam logic [1:0] RD = 2'd1;
  localparam logic [1:0] WR = 2'd2;
  localparam logic [AW-1:0] A0 = 8'h12;  // index 2, tag 2
  localparam logic [AW-1:0] A1 = 8'h1A;  // index 2, tag 3

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_update_snooper #(.AW(AW), .DW(DW), .NLINES(8), .IDW(IDW), .MY_ID(0), .RELOAD(3)) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .bc_req(bc_req), .bc_wr(bc_wr), .bc_addr(bc_addr), .bc_data(bc_data),
    .bus_valid(bus_valid), .bus_op(bus_op), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_src(bus_src), .shared_in(shared_in), .shared_out(shared_out),
    .sup_valid(sup_valid), .sup_data(sup_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic grab();
    k_done = cpu_done; k_hit = cpu_hit; k_rdata = cpu_rdata;
    k_bc = bc_req; k_bcwr = bc_wr; k_bcaddr = bc_addr; k_bcdata = bc_data;
    k_shr = shared_out; k_sup = sup_valid; k_supd = sup_data;
  endtask

  task automatic cpu_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    grab();
    cpu_req = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic bus_tx(input logic [1:0] op, input logic [IDW-1:0] src,
                        input logic [AW-1:0] a, input logic [DW-1:0] d, input logic shin);
    bus_valid = 1'b1; bus_op = op; bus_src = src; bus_addr = a; bus_data = d;
    @(negedge clk);
    grab();
    bus_valid = 1'b0; bus_op = 2'd0; shared_in = shin;
    @(negedge clk);
    shared_in = 1'b0;
  endtask

  task automatic both(input logic [1:0] op, input logic [IDW-1:0] src, input logic [DW-1:0] d,
                      input logic wr, input logic [AW-1:0] a);
    bus_valid = 1'b1; bus_op = op; bus_src = src; bus_addr = a; bus_data = d;
    cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = '0;
    @(negedge clk);
    grab();
    bus_valid = 1'b0; bus_op = 2'd0; cpu_req = 1'b0; cpu_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cpu_done", cpu_done, 0);
    chk("R1 bc_req", bc_req, 0);
    chk("R1 shared_out", shared_out, 0);
    chk("R1 sup_valid", sup_valid, 0);
    cpu_op(1'b0, A0, '0);
    chk("R1 first read misses", k_hit, 0);
    chk("R1 done", k_done, 1);
    chk("R2 miss requests", k_bc, 1);
    chk("R2 request is read", k_bcwr, 0);
    chk("R2 request addr", k_bcaddr, A0);
  endtask

  task automatic t_fill_and_dirty();
    bus_tx(RD, 2'd0, A0, 16'h1111, 1'b0);
    chk("R11 own echo not shared", k_shr, 0);
    cpu_op(1'b1, A0, 16'h2222);
    chk("R2 hit after fill", k_hit, 1);
    chk("R3 write to exclusive no bus", k_bc, 0);
    bus_tx(RD, 2'd1, A0, 16'h0000, 1'b0);
    chk("R3 supply valid", k_sup, 1);
    chk("R3 supply data", k_supd, 16'h2222);
    chk("R3 shared on dirty read", k_shr, 1);
  endtask

  task automatic t_shared_write();
    cpu_op(1'b1, A0, 16'h3333);
    chk("R4 shared write hit", k_hit, 1);
    chk("R4 broadcast req", k_bc, 1);
    chk("R4 broadcast is write", k_bcwr, 1);
    chk("R4 broadcast addr", k_bcaddr, A0);
    chk("R4 broadcast data", k_bcdata, 16'h3333);
    bus_tx(WR, 2'd0, A0, 16'h3333, 1'b0);
    chk("R11 own write echo not shared", k_shr, 0);
    cpu_op(1'b1, A0, 16'h4444);
    chk("R4 exclusive after lone broadcast", k_bc, 0);
    cpu_op(1'b0, A0, '0);
    chk("R4 read back", k_rdata, 16'h4444);
    bus_tx(RD, 2'd1, A0, '0, 1'b0);
    chk("R3 second supply", k_supd, 16'h4444);
  endtask

  task automatic t_shared_fill();
    cpu_op(1'b0, 8'h25, '0);
    chk("R2 miss other line", k_bc, 1);
    bus_tx(RD, 2'd0, 8'h25, 16'h0A0A, 1'b1);
    cpu_op(1'b1, 8'h25, 16'h0B0B);
    chk("R2 shared fill then write broadcasts", k_bc, 1);
  endtask

  task automatic t_count();
    bus_tx(WR, 2'd1, A0, 16'h5000, 1'b0);
    chk("R5 first update shared", k_shr, 1);
    bus_tx(WR, 2'd1, A0, 16'h5001, 1'b0);
    chk("R5 second update shared", k_shr, 1);
    bus_tx(WR, 2'd1, A0, 16'h5002, 1'b0);
    chk("R6 third drops copy", k_shr, 0);
    cpu_op(1'b0, A0, '0);
    chk("R6 read misses after drop", k_hit, 0);
    chk("R6 miss requests", k_bc, 1);
  endtask

  task automatic t_reread();
    bus_tx(RD, 2'd2, A0, 16'h6000, 1'b0);
    chk("R9 stale copy refilled shared", k_shr, 1);
    bus_tx(WR, 2'd2, A0, 16'h6001, 1'b0);
    chk("R9 counter preset 1", k_shr, 1);
    bus_tx(WR, 2'd2, A0, 16'h6002, 1'b0);
    chk("R9 counter preset 2", k_shr, 1);
    bus_tx(WR, 2'd2, A0, 16'h6003, 1'b0);
    chk("R9 counter then drops", k_shr, 0);
    bus_tx(RD, 2'd1, A0, 16'h6100, 1'b0);
    cpu_op(1'b0, A0, '0);
    chk("R9 refilled data", k_rdata, 16'h6100);
    chk("R9 refilled hit", k_hit, 1);
  endtask

  task automatic t_source();
    bus_tx(WR, 2'd1, A0, 16'h7000, 1'b0);
    bus_tx(WR, 2'd1, A0, 16'h7001, 1'b0);
    bus_tx(WR, 2'd2, A0, 16'h7002, 1'b0);
    chk("R7 new source restarts count", k_shr, 1);
    bus_tx(WR, 2'd2, A0, 16'h7003, 1'b0);
    chk("R7 new source second", k_shr, 1);
    bus_tx(WR, 2'd2, A0, 16'h7004, 1'b0);
    chk("R7 new source third drops", k_shr, 0);
    bus_tx(RD, 2'd1, A0, 16'h7100, 1'b0);
  endtask

  task automatic t_reuse();
    bus_tx(WR, 2'd1, A0, 16'h7200, 1'b0);
    bus_tx(WR, 2'd1, A0, 16'h7201, 1'b0);
    cpu_op(1'b0, A0, '0);
    chk("R8 local hit", k_hit, 1);
    chk("R5 data from broadcast", k_rdata, 16'h7201);
    bus_tx(WR, 2'd1, A0, 16'h7202, 1'b0);
    chk("R8 kept after reuse 1", k_shr, 1);
    bus_tx(WR, 2'd1, A0, 16'h7203, 1'b0);
    chk("R8 kept after reuse 2", k_shr, 1);
    bus_tx(WR, 2'd1, A0, 16'h7204, 1'b0);
    chk("R8 drop after full count", k_shr, 0);
    bus_tx(RD, 2'd1, A0, 16'h7300, 1'b0);
  endtask

  task automatic t_same_cycle();
    both(WR, 2'd1, 16'h8000, 1'b0, A0);
    chk("R10 cpu sees snooped data", k_rdata, 16'h8000);
    chk("R10 cpu hit", k_hit, 1);
    chk("R10 shared", k_shr, 1);
    bus_tx(WR, 2'd1, A0, 16'h8001, 1'b0);
    bus_tx(WR, 2'd1, A0, 16'h8002, 1'b0);
    both(WR, 2'd1, 16'h8003, 1'b0, A0);
    chk("R10 cpu misses after drop", k_hit, 0);
    chk("R10 miss request", k_bc, 1);
    chk("R10 shared low", k_shr, 0);
    bus_tx(RD, 2'd1, A0, 16'h8100, 1'b0);
  endtask

  task automatic t_other_tag();
    bus_tx(WR, 2'd1, A1, 16'h9000, 1'b0);
    chk("R12 foreign write other tag", k_shr, 0);
    bus_tx(RD, 2'd1, A1, 16'h9001, 1'b0);
    chk("R12 foreign read other tag shared", k_shr, 0);
    chk("R12 foreign read other tag supply", k_sup, 0);
    cpu_op(1'b0, A0, '0);
    chk("R12 line untouched hit", k_hit, 1);
    chk("R12 line untouched data", k_rdata, 16'h8100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill_and_dirty();
    t_shared_write();
    t_shared_fill();
    t_count();
    t_reread();
    t_source();
    t_reuse();
    t_same_cycle();
    t_other_tag();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule